// File: doc/BRIEF.md
# Masked Fast/Normal Interrupt Router

This block gathers sixteen interrupt sources and gates each one with its own bit of a mask register. It then folds the survivors into two processor request lines. Sources 0 to 3 feed the fast request line. Sources 4 to 15 feed the normal request line. Most sources are levels that the owning peripheral holds and clears, and they pass straight through. Two sources are held in this block.

The first held source is a modem-status change flag. It sets when either of two asynchronous modem lines changes level, in either direction. Each line is synchronized through two flops before its edges are detected. The flag stays set until software writes to a dedicated end-of-interrupt register. The second held source is a serial end-of-transfer flag. A completion pulse sets it, and the strobe raised when the host reads the serial data register clears it.

Software uses a small synchronous register bus with three word addresses:
- Address 0 is the mask register, readable and writable.
- Address 1 is the raw status, read-only.
- Address 2 is the end-of-interrupt location, write-only.

Top module: `irq_router`

## Requirements
- R1: Address 0 holds a 32-bit mask register. Bits 15:0 are writable and read back as written. Bits 31:16 read as zero, and writing them has no effect.
- R2: A synchronous active-high reset clears the mask, the modem-change flag and the end-of-transfer flag. After reset both request outputs are low.
- R3: `fiq_req` is high exactly when some bit k in 0..3 has both status bit k and mask bit k set. It follows a mask write in the cycle after the write edge, and it follows a source level in the same cycle.
- R4: `irq_req` is high exactly when some bit k in 4..15 has both status bit k and mask bit k set. It has the same timing as the fast line.
- R5: A read of address 1 returns the raw status in bits 15:0 whatever the mask holds, with zeros above. The status bit order, from bit 0 upward, is:
  - bit 0: external fast input
  - bit 1: battery low
  - bit 2: watchdog
  - bit 3: media change
  - bit 4: codec
  - bit 5: external 1
  - bit 6: external 2
  - bit 7: external 3
  - bit 8: timer 1 overflow
  - bit 9: timer 2 overflow
  - bit 10: RTC match
  - bit 11: tick
  - bit 12: UART transmit
  - bit 13: UART receive
  - bit 14: modem change
  - bit 15: serial end-of-transfer
- R6: A level change on either modem line, rising or falling, sets status bit 14. The bit becomes visible after the third rising clock edge that follows the change.
- R7: Status bit 14 is cleared only by a write to address 2. Writes to other addresses, and reads, leave it unchanged.
- R8: If a modem change would set bit 14 in the same cycle that an address 2 write clears it, the bit stays set.
- R9: A `xfer_done` pulse sets status bit 15 after one edge, and a `xfer_rd` pulse clears it after one edge. When both are high in the same cycle, the bit is set.
- R10: Input `src_level` bits 14 and 15 are ignored. Those status positions come only from the internal flags.
- R11: Read data appears on `bus_rdata` after the edge that samples a read and holds until the next read. Reads of address 2 and of any address above 2 return zero. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 16 | Level interrupt sources; bits 14 and 15 are unused |
| mdm_in | input | 2 | Asynchronous modem status lines |
| xfer_done | input | 1 | Serial transfer-complete pulse |
| xfer_rd | input | 1 | Serial data-register read strobe |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fiq_req | output | 1 | Fast request output (sources 0..3) |
| irq_req | output | 1 | Normal request output (sources 4..15) |

## Verification
Each result has its own latency:
- A level source reaches a request line within the same cycle.
- A mask write takes effect at its own edge.
- The end-of-transfer flag moves one edge after its pulse.
- The modem flag needs three edges: two synchronizer stages plus the latch.

The bench drives every input on the falling edge and samples on a later falling edge. For the modem path it checks that the request is still low after the second rising edge and high after the third. For the same-cycle case it places the end-of-interrupt write exactly on that third edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NUM_SRC   = 16;
    localparam int FAST_SRC  = 4;
    localparam int BUS_DW    = 32;
    localparam int BUS_AW    = 4;
    localparam int MDM_LINES = 2;
    localparam int SYNC_LEN  = 2;

    // Source positions within the status word (order matters to software)
    localparam int SRC_EXT_FAST = 0;
    localparam int SRC_BATT_LOW = 1;
    localparam int SRC_WDOG     = 2;
    localparam int SRC_MEDIA    = 3;
    localparam int SRC_CODEC    = 4;
    localparam int SRC_EXT1     = 5;
    localparam int SRC_EXT2     = 6;
    localparam int SRC_EXT3     = 7;
    localparam int SRC_TMR1     = 8;
    localparam int SRC_TMR2     = 9;
    localparam int SRC_RTC      = 10;
    localparam int SRC_TICK     = 11;
    localparam int SRC_UTX      = 12;
    localparam int SRC_URX      = 13;
    localparam int SRC_MODEM    = 14;
    localparam int SRC_SEOT     = 15;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_STATUS = 2'd1,
        REG_EOI    = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        case (a)
            BUS_AW'(0): return REG_MASK;
            BUS_AW'(1): return REG_STATUS;
            BUS_AW'(2): return REG_EOI;
            default:    return REG_NONE;
        endcase
    endfunction

    function automatic logic [NUM_SRC-1:0] fast_group();
        logic [NUM_SRC-1:0] g;
        for (int i = 0; i < NUM_SRC; i++) g[i] = (i < FAST_SRC);
        return g;
    endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int WIDTH  = irq_router_pkg::MDM_LINES,
    parameter int STAGES = irq_router_pkg::SYNC_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic             change
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign change = |(stage_q[STAGES-1] ^ prev_q);

    // R6: a detected change is consumed by the next edge
    assert_change_single_R6: assert property (@(posedge clk) disable iff (rst)
        change |=> (prev_q == $past(stage_q[STAGES-1])));
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    // R8 / R9: set has priority over clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);
    // R7: clear without set drops the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q);
    // R7: nothing else moves the flag
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int DW   = BUS_DW,
    parameter int AW   = BUS_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NSRC-1:0] status_i,
    output logic [NSRC-1:0] mask_o,
    output logic [DW-1:0]   rdata_o,
    output logic            eoi_o
);
    bus_op_t        op;
    logic [DW-1:0]  rd_mux;
    logic           unused_wdata_hi;

    always_comb begin
        op.rd  = bus_sel && !bus_wr;
        op.wr  = bus_sel && bus_wr;
        op.sel = decode_addr(bus_addr);
    end

    always_comb begin
        rd_mux = '0;
        case (op.sel)
            REG_MASK:   rd_mux[NSRC-1:0] = mask_o;
            REG_STATUS: rd_mux[NSRC-1:0] = status_i;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o  <= '0;
            rdata_o <= '0;
        end else begin
            if (op.wr && op.sel == REG_MASK) mask_o <= bus_wdata[NSRC-1:0];
            if (op.rd) rdata_o <= rd_mux;
        end
    end

    assign eoi_o           = op.wr && (op.sel == REG_EOI);
    assign unused_wdata_hi = ^bus_wdata[DW-1:NSRC];

    // R1: mask changes only on a write to its own address
    assert_mask_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr == '0) |=> $stable(mask_o));
    // R11: read data holds between reads
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> $stable(rdata_o));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC  = NUM_SRC,
    parameter int DW    = BUS_DW,
    parameter int AW    = BUS_AW,
    parameter int NMDM  = MDM_LINES,
    parameter int NSYNC = SYNC_LEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_level,
    input  logic [NMDM-1:0] mdm_in,
    input  logic            xfer_done,
    input  logic            xfer_rd,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            fiq_req,
    output logic            irq_req
);
    localparam logic [NSRC-1:0] FAST_SEL = fast_group();

    logic            mdm_change;
    logic            mdm_flag;
    logic            seot_flag;
    logic            eoi_pulse;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] armed;
    logic            unused_src;

    irq_sync_edge #(.WIDTH(NMDM), .STAGES(NSYNC)) u_mdm_sync (
        .clk(clk), .rst(rst), .din(mdm_in), .change(mdm_change)
    );

    irq_sticky u_mdm_flag (
        .clk(clk), .rst(rst), .set_i(mdm_change), .clr_i(eoi_pulse), .q(mdm_flag)
    );

    irq_sticky u_seot_flag (
        .clk(clk), .rst(rst), .set_i(xfer_done), .clr_i(xfer_rd), .q(seot_flag)
    );

    irq_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status_i(status),
        .mask_o(mask_q), .rdata_o(bus_rdata), .eoi_o(eoi_pulse)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_status
        if (i == SRC_MODEM) begin : g_mdm
            assign status[i] = mdm_flag;
        end else if (i == SRC_SEOT) begin : g_seot
            assign status[i] = seot_flag;
        end else begin : g_lvl
            assign status[i] = src_level[i];
        end
    end

    assign armed      = status & mask_q;
    assign fiq_req    = |(armed & FAST_SEL);
    assign irq_req    = |(armed & ~FAST_SEL);
    assign unused_src = src_level[SRC_MODEM] ^ src_level[SRC_SEOT];

    // R3: a fully masked fast group keeps the fast line quiet
    assert_fast_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & FAST_SEL) == '0) |-> !fiq_req);
    // R4: a fully masked normal group keeps the normal line quiet
    assert_slow_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & ~FAST_SEL) == '0) |-> !irq_req);
    // R1: reserved read bits stay zero
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DW-1:NSRC] == '0);
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_level = '0;
    logic [1:0]  mdm_in = '0;
    logic        xfer_done = 1'b0;
    logic        xfer_rd = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_req;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst(rst), .src_level(src_level), .mdm_in(mdm_in),
        .xfer_done(xfer_done), .xfer_rd(xfer_rd),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fiq_req(fiq_req), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        src_level = 16'h3FFF;
        @(negedge clk);
        check("R2 fiq after reset", {31'b0, fiq_req}, 32'h0);
        check("R2 irq after reset", {31'b0, irq_req}, 32'h0);
        bus_read(4'd0, d);
        check("R2 mask after reset", d, 32'h0);
        src_level = '0;
        bus_read(4'd1, d);
        check("R2 status after reset", d, 32'h0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        bus_write(4'd0, 32'hFFFF_A5C3);
        bus_read(4'd0, d);
        check("R1 mask readback", d, 32'h0000_A5C3);
        bus_write(4'd1, 32'hFFFF_FFFF);
        bus_read(4'd0, d);
        check("R11 status write ignored", d, 32'h0000_A5C3);
        bus_read(4'd2, d);
        check("R11 eoi reads zero", d, 32'h0);
        bus_read(4'd9, d);
        check("R11 unmapped reads zero", d, 32'h0);
    endtask

    task automatic t_fast_route();
        bus_write(4'd0, 32'h0000_000F);
        for (int k = 0; k < 4; k++) begin
            src_level = 16'(1 << k);
            @(negedge clk);
            check("R3 fast source routes", {30'b0, fiq_req, irq_req}, 32'h2);
        end
        src_level = 16'h3FF0;
        @(negedge clk);
        check("R3 slow sources stay off fast line", {30'b0, fiq_req, irq_req}, 32'h0);
        bus_write(4'd0, 32'h0000_000A);
        src_level = 16'h0005;
        @(negedge clk);
        check("R3 masked fast bits blocked", {31'b0, fiq_req}, 32'h0);
        src_level = '0;
    endtask

    task automatic t_slow_route();
        bus_write(4'd0, 32'h0000_FFF0);
        src_level = 16'h0010;
        @(negedge clk);
        check("R4 bit4 routes normal", {30'b0, fiq_req, irq_req}, 32'h1);
        src_level = 16'h2000;
        @(negedge clk);
        check("R4 bit13 routes normal", {30'b0, fiq_req, irq_req}, 32'h1);
        src_level = 16'h000F;
        @(negedge clk);
        check("R4 fast bits off normal line", {30'b0, fiq_req, irq_req}, 32'h0);
        src_level = '0;
    endtask

    task automatic t_status_raw();
        logic [31:0] d;
        bus_write(4'd0, 32'h0);
        src_level = 16'h2A5B;
        bus_read(4'd1, d);
        check("R5 raw status with mask clear", d, 32'h0000_2A5B);
        check("R5 no request with mask clear", {30'b0, fiq_req, irq_req}, 32'h0);
        src_level = '0;
    endtask

    task automatic t_ignored_src();
        logic [31:0] d;
        bus_write(4'd0, 32'h0000_C000);
        src_level = 16'hC000;
        @(negedge clk);
        check("R10 top src bits ignored", {31'b0, irq_req}, 32'h0);
        bus_read(4'd1, d);
        check("R10 status 15:14 from flags", d, 32'h0);
        src_level = '0;
    endtask

    task automatic t_modem();
        logic [31:0] d;
        bus_write(4'd0, 32'h0000_4000);
        @(negedge clk);
        mdm_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 not yet after two edges", {31'b0, irq_req}, 32'h0);
        @(negedge clk);
        check("R6 rising change latched", {31'b0, irq_req}, 32'h1);
        bus_write(4'd0, 32'h0000_4000);
        bus_write(4'd1, 32'h0);
        bus_read(4'd1, d);
        check("R7 other accesses keep flag", d, 32'h0000_4000);
        bus_write(4'd2, 32'h0);
        check("R7 eoi clears flag", {31'b0, irq_req}, 32'h0);
        // falling change on the first line
        @(negedge clk);
        mdm_in[0] = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 falling change latched", {31'b0, irq_req}, 32'h1);
        bus_write(4'd2, 32'h0);
        // other line, rising
        @(negedge clk);
        mdm_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 second line change latched", {31'b0, irq_req}, 32'h1);
        bus_write(4'd2, 32'h0);
        check("R7 eoi clears second flag", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        mdm_in[1] = 1'b0;
        @(negedge clk);
        bus_write(4'd2, 32'h0);
        check("R8 change wins over eoi", {31'b0, irq_req}, 32'h1);
        bus_write(4'd2, 32'h0);
        check("R8 later eoi clears", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_serial();
        logic [31:0] d;
        bus_write(4'd0, 32'h0000_8000);
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check("R9 done sets flag", {31'b0, irq_req}, 32'h1);
        bus_read(4'd1, d);
        check("R9 status bit15 set", d, 32'h0000_8000);
        xfer_rd = 1'b1;
        @(negedge clk);
        xfer_rd = 1'b0;
        check("R9 data read clears flag", {31'b0, irq_req}, 32'h0);
        xfer_done = 1'b1; xfer_rd = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; xfer_rd = 1'b0;
        check("R9 set wins over clear", {31'b0, irq_req}, 32'h1);
        xfer_rd = 1'b1;
        @(negedge clk);
        xfer_rd = 1'b0;
        check("R9 cleared again", {31'b0, irq_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mask_rw();
        t_fast_route();
        t_slow_route();
        t_status_raw();
        t_ignored_src();
        t_modem();
        t_same_cycle();
        t_serial();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule